// File: doc/BRIEF.md
# Code-Selected 32-bit Arithmetic Unit with Multiply and Divide

This block is the arithmetic-logic unit of a small RISC core. It receives a first operand (R1), a second operand (R0) and a control word. The operation is taken from the low byte of that control word, which normally comes straight from a dedicated control register. The code stays in force for as many operations as the core issues until software rewrites the register. The unit returns a 32-bit result together with a negative flag and a zero flag. It produces no carry or overflow indication.

A one-cycle `start` pulse launches an operation. Most operations finish on the next clock edge. Divide and remainder use a shift-subtract divider and finish 32 cycles after `start`. `done` pulses for one cycle when the result and flags become valid. The result and flags then hold until the next completion. A `start` that arrives while a divide is in progress is dropped.

Top module: `opsel_alu`

## Requirements
- R1: After reset, `done` is 0, `result` is 0, `flag_neg` is 0 and `flag_zero` is 1.
- R2: Code 0 gives R1+R0 and code 1 gives R1−R0. Both wrap modulo 2^32. Code 4 gives OR, code 5 gives AND and code 6 gives XOR. Code 7 gives ~R1, and R0 has no effect on its result.
- R3: Code 8 compares R1 and R0 as signed values and returns 32'h00000001 when R1>R0, 0 when they are equal, and 32'hFFFFFFFF when R1<R0. Code 9 returns R1 unchanged.
- R4: Code 12 shifts R1 left and code 13 shifts R1 right logically, filling with zeros. In both cases the shift amount is R0[4:0], and R0[31:5] is ignored.
- R5: Codes 14 and 15 form the unsigned 64-bit product R1·R0. Code 14 returns bits 31:0 and code 15 returns bits 63:32.
- R6: Code 16 returns the unsigned quotient of R1/R0. Code 18 returns the unsigned remainder R1 − R0·(R1/R0).
- R7: Codes 17 (quotient) and 19 (remainder) divide |R1| by |R0|. The result is negated when R1[31] XOR R0[31] is 1.
- R8: Division by zero gives quotient 32'hFFFFFFFF for codes 16 and 17 and gives R1 unchanged for codes 18 and 19. It completes with the normal divide latency.
- R9: On each completion, `flag_neg` equals result bit 31 and `flag_zero` is 1 exactly when the result is zero.
- R10: For every code other than 16 to 19, `done` pulses one cycle after the cycle in which `start` was sampled. For codes 16 to 19, `done` comes 32 cycles after it.
- R11: A `start` asserted while a divide is in progress is ignored and produces no extra `done`. Between completions, `result`, `flag_neg` and `flag_zero` hold their values whatever the operand and control inputs do.
- R12: The operation code is `ctrl_word[7:0]`, and bits 31:8 are ignored. Undefined codes (2, 3, 10, 11 and 20 to 255) return 0 with `flag_zero` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation (sampled when idle) |
| ctrl_word | input | 32 | Control register value; low byte selects the operation |
| opnd_a | input | 32 | First operand (R1) |
| opnd_b | input | 32 | Second operand (R0) |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 32 | Operation result |
| flag_neg | output | 1 | Negative flag |
| flag_zero | output | 1 | Zero flag |

## Verification
Operands are chosen so that each pair of neighbouring operations gives different answers. An all-ones times all-ones multiply separates the low half from the high half and signed from unsigned treatment. A shift count above 31 shows whether only the low five bits are used. Signed compare uses −1 against 1, where an unsigned compare would give the opposite answer. Signed divide and remainder are run with each sign combination, which exposes any sign rule other than the operand-sign XOR. Zero divisors, wrap-around sums and undefined codes carrying random upper control bits check the edge behaviour. A start issued in the middle of a divide shows whether it is properly dropped.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CODE_W = 8;

    localparam logic [CODE_W-1:0] OPC_ADD  = 8'd0;
    localparam logic [CODE_W-1:0] OPC_SUB  = 8'd1;
    localparam logic [CODE_W-1:0] OPC_OR   = 8'd4;
    localparam logic [CODE_W-1:0] OPC_AND  = 8'd5;
    localparam logic [CODE_W-1:0] OPC_XOR  = 8'd6;
    localparam logic [CODE_W-1:0] OPC_NOT  = 8'd7;
    localparam logic [CODE_W-1:0] OPC_CMP  = 8'd8;
    localparam logic [CODE_W-1:0] OPC_TST  = 8'd9;
    localparam logic [CODE_W-1:0] OPC_SHL  = 8'd12;
    localparam logic [CODE_W-1:0] OPC_SHR  = 8'd13;
    localparam logic [CODE_W-1:0] OPC_MULL = 8'd14;
    localparam logic [CODE_W-1:0] OPC_MULH = 8'd15;
    localparam logic [CODE_W-1:0] OPC_DIVU = 8'd16;
    localparam logic [CODE_W-1:0] OPC_DIVS = 8'd17;
    localparam logic [CODE_W-1:0] OPC_REMU = 8'd18;
    localparam logic [CODE_W-1:0] OPC_REMS = 8'd19;

    function automatic logic is_div_code(input logic [CODE_W-1:0] c);
        return (c >= OPC_DIVU) && (c <= OPC_REMS);
    endfunction

    function automatic logic is_signed_div(input logic [CODE_W-1:0] c);
        return (c == OPC_DIVS) || (c == OPC_REMS);
    endfunction

    function automatic logic is_rem_code(input logic [CODE_W-1:0] c);
        return (c == OPC_REMU) || (c == OPC_REMS);
    endfunction

endpackage

// File: rtl/opsel_alu_comb.sv
module opsel_alu_comb
    import opsel_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      res
);
    localparam int unsigned SH_W = $clog2(W);

    logic [2*W-1:0] prod;
    logic [W-1:0]   cmp_val;
    logic [SH_W-1:0] sh_amt;

    always_comb begin
        prod   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        sh_amt = b[SH_W-1:0];
        if ($signed(a) > $signed(b))
            cmp_val = W'(1);
        else if (a == b)
            cmp_val = '0;
        else
            cmp_val = '1;
    end

    always_comb begin
        unique case (code)
            OPC_ADD:  res = a + b;
            OPC_SUB:  res = a - b;
            OPC_OR:   res = a | b;
            OPC_AND:  res = a & b;
            OPC_XOR:  res = a ^ b;
            OPC_NOT:  res = ~a;
            OPC_CMP:  res = cmp_val;
            OPC_TST:  res = a;
            OPC_SHL:  res = a << sh_amt;
            OPC_SHR:  res = a >> sh_amt;
            OPC_MULL: res = prod[W-1:0];
            OPC_MULH: res = prod[2*W-1:W];
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/opsel_alu_divider.sv
module opsel_alu_divider
    import opsel_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         sgn_mode,
    input  logic         want_rem,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] value
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dsr;
        logic          neg;
        logic          want_rem;
        logic          dbz;
        logic [W-1:0]  raw_a;
    } dstate_t;

    dstate_t st_q, st_d;

    logic [W:0]   src_rem, shifted, trial, step_rem;
    logic [W-1:0] src_quo, src_dsr, step_quo, mag_a, mag_b, mag_out;

    always_comb begin
        mag_a = (sgn_mode && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
        mag_b = (sgn_mode && divisor[W-1])  ? (~divisor + 1'b1)  : divisor;

        if (load) begin
            src_rem = '0;
            src_quo = mag_a;
            src_dsr = mag_b;
        end else begin
            src_rem = st_q.rem;
            src_quo = st_q.quo;
            src_dsr = st_q.dsr;
        end

        shifted = {src_rem[W-1:0], src_quo[W-1]};
        trial   = shifted - {1'b0, src_dsr};
        if (!trial[W]) begin
            step_rem = trial;
            step_quo = {src_quo[W-2:0], 1'b1};
        end else begin
            step_rem = shifted;
            step_quo = {src_quo[W-2:0], 1'b0};
        end

        fin     = st_q.busy && (st_q.cnt == LAST);
        mag_out = st_q.want_rem ? step_rem[W-1:0] : step_quo;
        if (st_q.dbz)
            value = st_q.want_rem ? st_q.raw_a : '1;
        else
            value = st_q.neg ? (~mag_out + 1'b1) : mag_out;
        busy = st_q.busy;

        st_d = st_q;
        if (load && !st_q.busy) begin
            st_d.busy     = 1'b1;
            st_d.cnt      = CW'(1);
            st_d.rem      = step_rem;
            st_d.quo      = step_quo;
            st_d.dsr      = mag_b;
            st_d.neg      = sgn_mode && (dividend[W-1] ^ divisor[W-1]);
            st_d.want_rem = want_rem;
            st_d.dbz      = (divisor == '0);
            st_d.raw_a    = dividend;
        end else if (st_q.busy) begin
            st_d.rem = step_rem;
            st_d.quo = step_quo;
            st_d.cnt = st_q.cnt + 1'b1;
            if (fin)
                st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    AST_DIV_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != LAST) |=> st_q.busy) else $error("divider left early"); // R10

    AST_DIV_FIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin) else $error("divider finished twice"); // R11

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !st_q.dbz) |-> (st_q.rem < {1'b0, st_q.dsr})) else $error("partial remainder too large"); // R6

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int unsigned W      = DATA_W,
    parameter int unsigned CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic              done,
    output logic [W-1:0]      result,
    output logic              flag_neg,
    output logic              flag_zero
);
    typedef struct packed {
        logic         done;
        logic [W-1:0] result;
        logic         neg;
        logic         zero;
    } ostate_t;

    ostate_t os_q, os_d;

    logic [CODE_W-1:0] code;
    logic [W-1:0]      comb_res, div_val;
    logic              div_busy, div_fin, div_load, take;

    assign code = ctrl_word[CODE_W-1:0];

    opsel_alu_comb #(.W(W)) comb_i (
        .code (code),
        .a    (opnd_a),
        .b    (opnd_b),
        .res  (comb_res)
    );

    opsel_alu_divider #(.W(W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .sgn_mode (is_signed_div(code)),
        .want_rem (is_rem_code(code)),
        .dividend (opnd_a),
        .divisor  (opnd_b),
        .busy     (div_busy),
        .fin      (div_fin),
        .value    (div_val)
    );

    always_comb begin
        take     = start && !div_busy;
        div_load = take && is_div_code(code);

        os_d      = os_q;
        os_d.done = 1'b0;
        if (div_fin) begin
            os_d.done   = 1'b1;
            os_d.result = div_val;
        end else if (take && !is_div_code(code)) begin
            os_d.done   = 1'b1;
            os_d.result = comb_res;
        end
        if (os_d.done) begin
            os_d.neg  = os_d.result[W-1];
            os_d.zero = (os_d.result == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q        <= '0;
            os_q.zero   <= 1'b1;
        end else begin
            os_q <= os_d;
        end
    end

    assign done      = os_q.done;
    assign result    = os_q.result;
    assign flag_neg  = os_q.neg;
    assign flag_zero = os_q.zero;

    AST_QUICK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !div_busy && !is_div_code(code)) |=> done) else $error("single-cycle op late"); // R10

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(flag_neg) && $stable(flag_zero))) else $error("output moved without done"); // R11

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !div_busy && !is_div_code(code) && (code == 8'd2 || code == 8'd3 || code == 8'd10 || code == 8'd11 || code > 8'd19))
        |=> (result == '0 && flag_zero)) else $error("undefined code gave data"); // R12

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_neg == result[W-1])) else $error("negative flag mismatch"); // R9

    AST_NOT_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !div_busy && code == OPC_NOT) |=> (result == ~$past(opnd_a))) else $error("not op wrong"); // R2

endmodule

// File: tb/opsel_alu_tb.sv
module opsel_alu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        done;
    logic [31:0] result;
    logic        flag_neg;
    logic        flag_zero;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [31:0] res;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic [31:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opsel_alu dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .done(done), .result(result),
        .flag_neg(flag_neg), .flag_zero(flag_zero)
    );

    function automatic logic [31:0] model(input logic [7:0] c, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        logic [31:0] ma, mb, q, r;
        logic        s;
        p  = {32'd0, a} * {32'd0, b};
        s  = (c == 8'd17 || c == 8'd19);
        ma = (s && a[31]) ? -a : a;
        mb = (s && b[31]) ? -b : b;
        q  = (mb != 0) ? ma / mb : 32'hFFFF_FFFF;
        r  = (mb != 0) ? ma % mb : a;
        case (c)
            8'd0:  return a + b;
            8'd1:  return a - b;
            8'd4:  return a | b;
            8'd5:  return a & b;
            8'd6:  return a ^ b;
            8'd7:  return ~a;
            8'd8:  return ($signed(a) > $signed(b)) ? 32'd1 : ((a == b) ? 32'd0 : 32'hFFFF_FFFF);
            8'd9:  return a;
            8'd12: return a << b[4:0];
            8'd13: return a >> b[4:0];
            8'd14: return p[31:0];
            8'd15: return p[63:32];
            8'd16, 8'd18, 8'd17, 8'd19: begin
                logic [31:0] m;
                m = (c == 8'd16 || c == 8'd17) ? q : r;
                if (mb == 0) return m;
                return (s && (a[31] ^ b[31])) ? -m : m;
            end
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop scoreboard on every completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check("R11 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " result"}, result, e.res);
                check("R9 neg flag", {31'd0, flag_neg}, {31'd0, e.res[31]});
                check("R9 zero flag", {31'd0, flag_zero}, {31'd0, e.res == 0});
                last_res = e.res;
            end
        end
    end

    task automatic run_op(input logic [7:0] c, input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t e;
        int lat;
        int want;
        e.res = model(c, a, b);
        e.tag = tag;
        sb_q.push_back(e);
        want = (c >= 8'd16 && c <= 8'd19) ? 32 : 1;
        @(negedge clk);
        start     = 1'b1;
        ctrl_word = {$urandom_range(0, 32'h00FF_FFFF) , 8'h00} | {24'd0, c}; // R12 upper bits random
        opnd_a    = a;
        opnd_b    = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check({"R10 latency ", tag}, lat, want);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 neg", {31'd0, flag_neg}, 32'd0);
        check("R1 zero", {31'd0, flag_zero}, 32'd1);

        run_op(8'd0, 32'd5, 32'd7, "R2 add");
        run_op(8'd0, 32'hFFFF_FFFF, 32'd1, "R2 add wrap");
        run_op(8'd1, 32'd3, 32'd5, "R2 sub");
        run_op(8'd4, 32'hF0F0_0000, 32'h0000_0F0F, "R2 or");
        run_op(8'd5, 32'hFF00_FF00, 32'h0FF0_0FF0, "R2 and");
        run_op(8'd6, 32'hAAAA_5555, 32'hFFFF_0000, "R2 xor");
        run_op(8'd7, 32'h1234_5678, 32'hDEAD_BEEF, "R2 not");
        run_op(8'd7, 32'h1234_5678, 32'h0000_0000, "R2 not other b");
        run_op(8'd8, 32'd9, 32'd4, "R3 cmp gt");
        run_op(8'd8, 32'hFFFF_FFFF, 32'd1, "R3 cmp signed lt");
        run_op(8'd8, 32'd42, 32'd42, "R3 cmp eq");
        run_op(8'd9, 32'h8000_0000, 32'd77, "R3 test neg");
        run_op(8'd9, 32'd0, 32'd5, "R3 test zero");
        run_op(8'd12, 32'h0000_0003, 32'd33, "R4 shl masked");
        run_op(8'd13, 32'h8000_0000, 32'd31, "R4 shr logical");
        run_op(8'd13, 32'hF000_0000, 32'hFFFF_FFE4, "R4 shr masked");
        run_op(8'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 mul low");
        run_op(8'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 mul high");
        run_op(8'd15, 32'h0001_0000, 32'h0003_0000, "R5 mul high small");
        run_op(8'd16, 32'd100, 32'd7, "R6 divu");
        run_op(8'd18, 32'd100, 32'd7, "R6 remu");
        run_op(8'd16, 32'hFFFF_FFFE, 32'd2, "R6 divu big");
        run_op(8'd17, -32'sd7, 32'd2, "R7 divs neg pos");
        run_op(8'd19, -32'sd7, 32'd2, "R7 rems neg pos");
        run_op(8'd19, 32'd7, -32'sd2, "R7 rems pos neg");
        run_op(8'd17, -32'sd100, -32'sd7, "R7 divs neg neg");
        run_op(8'd16, 32'd55, 32'd0, "R8 divu by zero");
        run_op(8'd19, -32'sd55, 32'd0, "R8 rems by zero");
        run_op(8'd17, 32'd9, 32'd0, "R8 divs by zero");
        run_op(8'd2, 32'd1, 32'd1, "R12 undef 2");
        run_op(8'd10, 32'd1, 32'd1, "R12 undef 10");
        run_op(8'd20, 32'hFFFF_FFFF, 32'd3, "R12 undef 20");
        run_op(8'd255, 32'd8, 32'd8, "R12 undef 255");

        // R11: outputs hold while inputs change without start
        run_op(8'd1, 32'd10, 32'd20, "R11 setup");
        @(negedge clk);
        ctrl_word = 32'd0; opnd_a = 32'd1; opnd_b = 32'd1;
        repeat (3) @(negedge clk);
        check("R11 hold result", result, 32'hFFFF_FFF6);
        check("R11 hold neg", {31'd0, flag_neg}, 32'd1);

        // R11: start during divide is ignored
        begin
            exp_t e;
            int lat;
            e.res = model(8'd16, 32'd1000, 32'd9);
            e.tag = "R11 busy divide";
            sb_q.push_back(e);
            @(negedge clk);
            start = 1'b1; ctrl_word = 32'd16; opnd_a = 32'd1000; opnd_b = 32'd9;
            @(negedge clk);
            start = 1'b0;
            lat = 1;
            repeat (4) begin @(negedge clk); lat++; end
            start = 1'b1; ctrl_word = 32'd0; opnd_a = 32'd3; opnd_b = 32'd3;
            @(negedge clk); lat++;
            start = 1'b0;
            while (!done && lat < 100) begin @(negedge clk); lat++; end
            check("R10 R11 divide latency with stray start", lat, 32);
            repeat (5) @(negedge clk);
            check("R11 no extra item", sb_q.size(), 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule